// File: doc/BRIEF.md
# Three-Channel Nonvolatile Wiper Register Bank

This block stores the tap settings of three digital potentiometers: a 64-tap, a 100-tap and a 256-tap channel. Each channel has two registers. The live wiper register drives a one-hot tap-enable bus. A persistent shadow register keeps its value when the volatile domain is reset, and that reset stands in for a power cycle. A write is either volatile, which touches only the live register, or persistent, which updates the live register and the shadow together. A persistent write holds the bank busy for a fixed number of cycles, and further writes are refused until it ends.

After the volatile reset is released, each live register holds a fixed pre-recall value. The supply-good input must then stay high for a selectable number of consecutive cycles. When it has, the bank copies every shadow into its live register and raises `ready`. Data bytes above a channel's top tap saturate at that top tap. A read port returns the live value of the selected channel.

Top module: `wiper_bank`

## Requirements
- R1: Channel 0 has 64 taps, channel 1 has 100 taps and channel 2 has 256 taps. A data byte that does not exceed a channel's top tap (3Fh, 63h, FFh) becomes that channel's binary tap index.
- R2: A data byte above a channel's top tap sets the wiper to the top tap. It never wraps to a low tap.
- R3: A volatile write (`wr_nv`=0) changes only the live register. After a volatile reset and recall, the channel shows its last persistent value.
- R4: A persistent write (`wr_nv`=1) updates the live register and the shadow together, so the value survives a volatile reset and recall.
- R5: While `rst_n` is low and until recall, the live values are 63 (channel 0), 0 (channel 1) and 255 (channel 2), and writes are ignored.
- R6: Recall happens at the clock edge where `supply_ok` has been high for 8<<`por_sel` consecutive edges after reset. If `supply_ok` drops, the count restarts. `ready` rises at that same edge and stays high until the next reset.
- R7: `nv_clear_n` low clears every shadow to 00h. A recall after that puts every wiper at tap 0.
- R8: `rd_data` returns the live register of channel `rd_ch`, not its shadow. Select value 3 is reserved: it reads 00h, and a write to it changes nothing.
- R9: Each tap-enable bus has exactly one bit set, at the index equal to the live value.
- R10: An accepted persistent write raises `busy` for exactly NV_BUSY_CYCLES cycles. Writes presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Volatile-domain reset (power), asynchronous active low |
| nv_clear_n | input | 1 | Shadow clear to the factory value, asynchronous active low |
| supply_ok | input | 1 | Supply above the trip level |
| por_sel | input | 2 | Recall delay select, 8<<por_sel cycles |
| wr_en | input | 1 | Write strobe |
| wr_ch | input | 2 | Write channel select (3 reserved) |
| wr_nv | input | 1 | 1 = persistent write, 0 = volatile write |
| wr_data | input | 8 | Write data byte |
| rd_ch | input | 2 | Read channel select |
| rd_data | output | 8 | Live wiper value of the read channel |
| busy | output | 1 | Persistent write in progress |
| ready | output | 1 | Recall done, writes allowed |
| tap0_en | output | 64 | One-hot tap enables, channel 0 |
| tap1_en | output | 100 | One-hot tap enables, channel 1 |
| tap2_en | output | 256 | One-hot tap enables, channel 2 |

## Verification
The bench goes after clamping at the exact top-tap boundaries (3Fh/40h, 63h/64h, FFh). A design that wraps would land a wiper on a low tap there. It repeats power cycles after mixed volatile and persistent writes, which would expose a volatile write that leaks into the shadow or a persistent write that misses it. It interrupts the supply count one edge before completion and counts the recall delay edge by edge, so an off-by-one or a count that fails to restart shows up as an early or late `ready`. It also counts the busy window exactly, injects a write inside it, and writes to the reserved select. A lax guard on either would let a stray value reach a wiper.

// File: rtl/wb_pkg.sv
package wb_pkg;
  localparam int DW = 8;
  typedef logic [DW-1:0] wiper_t;
  typedef enum logic [1:0] {
    CH_FINE = 2'd0,
    CH_MID  = 2'd1,
    CH_WIDE = 2'd2,
    CH_NONE = 2'd3
  } chsel_e;
endpackage

// File: rtl/wb_recall.sv
module wb_recall #(
  parameter int BASE = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic [1:0] por_sel,
  output logic       recall,
  output logic       ready
);
  localparam int CW = $clog2(BASE * 8) + 1;

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          done_d;

  assign lim    = CW'(BASE) << por_sel;
  assign recall = supply_ok && !ready && (cnt_q == lim - CW'(1));

  always_comb begin
    cnt_d  = cnt_q;
    done_d = ready;
    if (!ready) begin
      if (!supply_ok)  cnt_d = '0;
      else if (recall) done_d = 1'b1;
      else             cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ready <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ready <= done_d;
    end
  end
endmodule

// File: rtl/wb_busy.sv
module wb_busy #(
  parameter int CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int BW = $clog2(CYCLES + 1);

  logic [BW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign busy   = (cnt_q != '0);
  assign cnt_en = start || busy;

  always_comb begin
    if (start) cnt_d = BW'(CYCLES);
    else       cnt_d = cnt_q - BW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wb_channel.sv
module wb_channel
  import wb_pkg::*;
#(
  parameter int TAPS = 64,
  parameter int PRE  = 63
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nv_clear_n,
  input  logic            wr_stb,
  input  logic            wr_nv,
  input  wiper_t          wr_data,
  input  logic            recall,
  output wiper_t          wcr,
  output logic [TAPS-1:0] tap_en
);
  localparam logic [DW:0] LIMIT = (DW+1)'(TAPS);
  localparam wiper_t      TOP   = DW'(TAPS - 1);

  wiper_t wr_val, wcr_nxt, shadow;
  logic   wcr_en, sh_en;

  assign wr_val = ({1'b0, wr_data} >= LIMIT) ? TOP : wr_data;
  assign wcr_en = recall || wr_stb;
  assign sh_en  = wr_stb && wr_nv;

  always_comb begin
    if (recall) wcr_nxt = shadow;
    else        wcr_nxt = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wcr <= DW'(PRE);
    else if (wcr_en) wcr <= wcr_nxt;
  end

  always_ff @(posedge clk or negedge nv_clear_n) begin
    if (!nv_clear_n) shadow <= '0;
    else if (sh_en)  shadow <= wr_val;
  end

  for (genvar g = 0; g < TAPS; g++) begin : g_dec
    assign tap_en[g] = (wcr == DW'(g));
  end
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
  import wb_pkg::*;
#(
  parameter int TAPS0          = 64,
  parameter int TAPS1          = 100,
  parameter int TAPS2          = 256,
  parameter int PRE0           = 63,
  parameter int PRE1           = 0,
  parameter int PRE2           = 255,
  parameter int RECALL_BASE    = 8,
  parameter int NV_BUSY_CYCLES = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nv_clear_n,
  input  logic             supply_ok,
  input  logic [1:0]       por_sel,
  input  logic             wr_en,
  input  logic [1:0]       wr_ch,
  input  logic             wr_nv,
  input  logic [7:0]       wr_data,
  input  logic [1:0]       rd_ch,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             ready,
  output logic [TAPS0-1:0] tap0_en,
  output logic [TAPS1-1:0] tap1_en,
  output logic [TAPS2-1:0] tap2_en
);
  logic [1:0] rs_q;
  logic       rst_i_n, recall, accept, nv_start;
  wiper_t     wcr0, wcr1, wcr2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  assign accept   = wr_en && ready && !busy && (chsel_e'(wr_ch) != CH_NONE);
  assign nv_start = accept && wr_nv;

  wb_recall #(.BASE(RECALL_BASE)) u_recall (
    .clk(clk), .rst_n(rst_i_n), .supply_ok(supply_ok), .por_sel(por_sel),
    .recall(recall), .ready(ready)
  );

  wb_busy #(.CYCLES(NV_BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_i_n), .start(nv_start), .busy(busy)
  );

  wb_channel #(.TAPS(TAPS0), .PRE(PRE0)) u_ch0 (
    .clk(clk), .rst_n(rst_i_n), .nv_clear_n(nv_clear_n),
    .wr_stb(accept && (chsel_e'(wr_ch) == CH_FINE)), .wr_nv(wr_nv),
    .wr_data(wr_data), .recall(recall), .wcr(wcr0), .tap_en(tap0_en)
  );

  wb_channel #(.TAPS(TAPS1), .PRE(PRE1)) u_ch1 (
    .clk(clk), .rst_n(rst_i_n), .nv_clear_n(nv_clear_n),
    .wr_stb(accept && (chsel_e'(wr_ch) == CH_MID)), .wr_nv(wr_nv),
    .wr_data(wr_data), .recall(recall), .wcr(wcr1), .tap_en(tap1_en)
  );

  wb_channel #(.TAPS(TAPS2), .PRE(PRE2)) u_ch2 (
    .clk(clk), .rst_n(rst_i_n), .nv_clear_n(nv_clear_n),
    .wr_stb(accept && (chsel_e'(wr_ch) == CH_WIDE)), .wr_nv(wr_nv),
    .wr_data(wr_data), .recall(recall), .wcr(wcr2), .tap_en(tap2_en)
  );

  always_comb begin
    case (chsel_e'(rd_ch))
      CH_FINE: rd_data = wcr0;
      CH_MID:  rd_data = wcr1;
      CH_WIDE: rd_data = wcr2;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wiper_bank_chk.sv
module wiper_bank_chk #(
  parameter int TAPS0 = 64,
  parameter int TAPS1 = 100,
  parameter int TAPS2 = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_ch,
  input logic             wr_nv,
  input logic [7:0]       wr_data,
  input logic             busy,
  input logic             ready,
  input logic [TAPS0-1:0] tap0_en,
  input logic [TAPS1-1:0] tap1_en,
  input logic [TAPS2-1:0] tap2_en
);
  logic take;
  assign take = wr_en && ready && !busy && (wr_ch != 2'd3);

  AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(tap0_en) == 1) && ($countones(tap1_en) == 1) && ($countones(tap2_en) == 1)); // R9

  AST_PRE_RECALL: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (tap0_en[TAPS0-1] && tap1_en[0] && tap2_en[TAPS2-1])); // R5

  AST_CLAMP_LOW_CH: assert property (@(posedge clk) disable iff (!rst_n)
    (take && wr_ch == 2'd0 && int'(wr_data) >= TAPS0) |=> tap0_en[TAPS0-1]); // R2

  AST_CLAMP_MID_CH: assert property (@(posedge clk) disable iff (!rst_n)
    (take && wr_ch == 2'd1 && int'(wr_data) >= TAPS1) |=> tap1_en[TAPS1-1]); // R2

  AST_NV_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (take && wr_nv) |=> busy); // R10

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(tap0_en) && $stable(tap1_en) && $stable(tap2_en))); // R10

  AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready); // R6
endmodule

bind wiper_bank wiper_bank_chk #(.TAPS0(TAPS0), .TAPS1(TAPS1), .TAPS2(TAPS2)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_nv(wr_nv),
  .wr_data(wr_data), .busy(busy), .ready(ready),
  .tap0_en(tap0_en), .tap1_en(tap1_en), .tap2_en(tap2_en)
);

// File: tb/wiper_bank_bench.sv
`timescale 1ns/1ps
module wiper_bank_bench;
  localparam int NVB = 20;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, nv_clear_n, supply_ok, wr_en, wr_nv;
  logic [1:0] por_sel, wr_ch, rd_ch;
  logic [7:0] wr_data, rd_data;
  logic busy, ready;
  logic [63:0]  tap0_en;
  logic [99:0]  tap1_en;
  logic [255:0] tap2_en;

  wiper_bank #(.NV_BUSY_CYCLES(NVB)) u_wiper_bank (
    .clk(clk), .rst_n(rst_n), .nv_clear_n(nv_clear_n), .supply_ok(supply_ok),
    .por_sel(por_sel), .wr_en(wr_en), .wr_ch(wr_ch), .wr_nv(wr_nv),
    .wr_data(wr_data), .rd_ch(rd_ch), .rd_data(rd_data), .busy(busy),
    .ready(ready), .tap0_en(tap0_en), .tap1_en(tap1_en), .tap2_en(tap2_en)
  );

  int checks = 0, fails = 0;
  int exp_w[3], exp_s[3];
  logic mready;

  function automatic int top_of(int ch);
    return (ch == 0) ? 63 : (ch == 1) ? 99 : 255;
  endfunction
  function automatic int clampv(int ch, int d);
    return (d > top_of(ch)) ? top_of(ch) : d;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    for (int c = 0; c < 3; c++) begin
      int onec;
      bit hit;
      rd_ch = 2'(c);
      #0.2;
      check(int'(rd_data) == exp_w[c], {tag, " R8 read"}, int'(rd_data), exp_w[c]);
      if (c == 0)      begin onec = $countones(tap0_en); hit = tap0_en[exp_w[c]]; end
      else if (c == 1) begin onec = $countones(tap1_en); hit = tap1_en[exp_w[c]]; end
      else             begin onec = $countones(tap2_en); hit = tap2_en[exp_w[c]]; end
      check(hit && onec == 1, {tag, " R9 onehot"}, onec, 1);
    end
  endtask

  task automatic wr(input int ch, input bit nv, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = 2'(ch); wr_nv = nv; wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
    if (mready && ch != 3) begin
      exp_w[ch] = clampv(ch, d);
      if (nv) exp_s[ch] = clampv(ch, d);
    end
  endtask

  task automatic power_up(input int sel);
    int lim;
    lim = 8 << sel;
    repeat (4) @(negedge clk);
    por_sel = 2'(sel);
    supply_ok = 1'b1;
    repeat (lim - 1) @(negedge clk);
    check(ready == 1'b0, "R6 ready early", int'(ready), 0);
    @(negedge clk);
    check(ready == 1'b1, "R6 ready at limit", int'(ready), 1);
    mready = 1'b1;
    for (int c = 0; c < 3; c++) exp_w[c] = exp_s[c];
  endtask

  task automatic power_cycle(input int sel);
    @(negedge clk);
    rst_n = 1'b0; supply_ok = 1'b0; mready = 1'b0;
    exp_w[0] = 63; exp_w[1] = 0; exp_w[2] = 255;
    @(negedge clk);
    chk_all("R5 prerecall");
    rst_n = 1'b1;
    power_up(sel);
    chk_all("R3 R4 recall");
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed, cnt, lim;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    rst_n = 1'b0; nv_clear_n = 1'b0; supply_ok = 1'b0; por_sel = 2'd1;
    wr_en = 1'b0; wr_ch = 2'd0; wr_nv = 1'b0; wr_data = 8'd0; rd_ch = 2'd0;
    mready = 1'b0;
    exp_w[0] = 63; exp_w[1] = 0; exp_w[2] = 255;
    exp_s[0] = 0;  exp_s[1] = 0; exp_s[2] = 0;
    repeat (3) @(negedge clk);
    chk_all("R5 reset");
    check(busy == 1'b0 && ready == 1'b0, "R5 reset flags", int'({busy, ready}), 0);
    nv_clear_n = 1'b1; rst_n = 1'b1;
    repeat (4) @(negedge clk);
    wr(1, 1'b1, 5);
    chk_all("R5 write before recall");
    check(busy == 1'b0, "R5 no busy before recall", int'(busy), 0);

    // interrupted supply count, then full count (por_sel=1 -> 16 edges)
    supply_ok = 1'b1;
    repeat (15) @(negedge clk);
    supply_ok = 1'b0;
    @(negedge clk);
    check(ready == 1'b0, "R6 drop", int'(ready), 0);
    supply_ok = 1'b1;
    lim = 16;
    repeat (lim - 1) @(negedge clk);
    check(ready == 1'b0, "R6 restart count", int'(ready), 0);
    @(negedge clk);
    check(ready == 1'b1, "R6 ready", int'(ready), 1);
    mready = 1'b1;
    for (int c = 0; c < 3; c++) exp_w[c] = exp_s[c];
    chk_all("R7 factory default");

    // boundaries
    wr(0, 1'b0, 8'h3F); chk_all("R1 ch0 top");
    wr(0, 1'b0, 8'h40); chk_all("R2 ch0 over");
    wr(0, 1'b0, 8'h0A); chk_all("R1 ch0 mid");
    wr(1, 1'b0, 8'h63); chk_all("R1 ch1 top");
    wr(1, 1'b0, 8'h64); chk_all("R2 ch1 over");
    wr(1, 1'b0, 8'hFF); chk_all("R2 ch1 max");
    wr(2, 1'b0, 8'hFF); chk_all("R1 ch2 top");
    wr(2, 1'b0, 8'h00); chk_all("R1 ch2 zero");
    wr(3, 1'b0, 8'h21); chk_all("R8 reserved write");
    rd_ch = 2'd3; #0.2;
    check(rd_data == 8'h00, "R8 reserved read", int'(rd_data), 0);

    // persistent write, busy window, write during busy
    wr(2, 1'b1, 8'h80);
    cnt = 1;
    check(busy == 1'b1, "R10 busy raised", int'(busy), 1);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = 2'd2; wr_nv = 1'b0; wr_data = 8'h05;
    if (busy) cnt++;
    @(negedge clk);
    wr_en = 1'b0;
    while (busy && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt == NVB, "R10 busy length", cnt, NVB);
    chk_all("R10 write during busy ignored");
    wr(2, 1'b0, 8'h11);
    chk_all("R8 read live not shadow");
    wr(0, 1'b0, 8'h2C);
    power_cycle(0);

    // constrained random
    for (int i = 0; i < 60; i++) begin
      int ch, d;
      bit nv;
      ch = int'($urandom_range(0, 3));
      nv = ($urandom_range(0, 3) == 0);
      d  = ($urandom_range(0, 3) == 0) ? int'($urandom_range(250, 255)) : int'($urandom_range(0, 255));
      wr(ch, nv, d);
      chk_all("R1 R2 random");
      if (nv && ch != 3) repeat (NVB) @(negedge clk);
      if (i % 15 == 14) power_cycle(int'($urandom_range(0, 3)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule